// File: doc/BRIEF.md
# Hardware Break Request Controller

This block decides when a pipelined processor leaves its normal instruction flow to take an external debug break. Two request inputs reach it. The first is a maskable request, given as a level. It is honoured only while no break and no exception is being serviced. The second is a non-maskable request, given as a one-cycle pulse. It is honoured in the cycle it arrives, whatever the processor state.

When a break is taken, the block raises a take signal in that same cycle. The pipeline uses it to let the execute-stage instruction finish and to replace the decode-stage instruction with a jump to the break vector. The vector is a parameterised base address plus 0x18. In the same cycle the block asks the register file to store the decode-stage PC in general register R16, which is the break return address.

The block holds the break-in-progress flag. It sets the flag on every taken break and clears it when the return-from-break instruction executes. While the flag is set, or a break is being taken, the block drives an interrupt mask.

Top module: `dbg_break_ctrl`

## Requirements
- R1: In a cycle where `take_brk_o` is 1, `brk_target_o` equals `VEC_BASE + 0x18`, taken modulo 2^ADDR_W.
- R2: `r16_we_o` is 1 exactly in the cycles where `take_brk_o` is 1. In those cycles `r16_data_o` equals `dec_pc_i`.
- R3: A taken break makes `bip_o` equal 1 after the next rising clock edge.
- R4: A maskable request (`brk_lvl_i` = 1) produces `take_brk_o` = 1 only when `bip_o` = 0 and `msr_eip_i` = 0 in that cycle.
- R5: `brk_nm_i` = 1 produces `take_brk_o` = 1 in the same cycle, whatever the values of `bip_o` and `msr_eip_i`.
- R6: `rtb_exec_i` = 1 with no break taken in that cycle makes `bip_o` equal 0 after the next edge.
- R7: `irq_mask_o` is 1 whenever `bip_o` is 1 or `take_brk_o` is 1, and is 0 otherwise.
- R8: If the maskable level stays high after its break is taken, it produces no further break while `bip_o` remains 1.
- R9: If `rtb_exec_i` = 1 and a break is taken in the same cycle, `bip_o` stays 1 after the edge.
- R10: While `rst` = 1, `take_brk_o` and `r16_we_o` are 0. A rising edge with `rst` = 1 makes `bip_o` equal 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_lvl_i | input | 1 | Maskable break request, a level |
| brk_nm_i | input | 1 | Non-maskable break request, a one-cycle pulse |
| msr_eip_i | input | 1 | Exception-in-progress status bit |
| rtb_exec_i | input | 1 | Strobe: the return-from-break instruction is executing |
| dec_pc_i | input | ADDR_W | PC of the decode-stage instruction |
| take_brk_o | output | 1 | Squash the decode-stage instruction and branch to the vector |
| brk_target_o | output | ADDR_W | Break vector address |
| r16_we_o | output | 1 | Write enable for R16 |
| r16_data_o | output | ADDR_W | Return address to be written into R16 |
| bip_o | output | 1 | Break-in-progress flag |
| irq_mask_o | output | 1 | Interrupt mask |

## Verification
The bench builds the block with ADDR_W = 32 and VEC_BASE = 0xFFFF_FFF0. With that base, the vector sum crosses the top of the address space and lands on 0x0000_0008, so the R1 check also exercises the modular wrap of the target adder. At the default base of zero, a truncated or mis-sized adder would go unnoticed. The stimulus places maskable requests against each gating flag, non-maskable pulses while a break is already in progress, and a return strobe that coincides with a new break.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    // Offset of the break vector from the vector base
    localparam logic [31:0] BRK_VEC_OFS = 32'h0000_0018;

    // Action applied to the break-in-progress flag at the next edge
    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'b00,
        FLAG_SET   = 2'b01,
        FLAG_CLEAR = 2'b10
    } flag_op_e;

    // Outcome of request arbitration for one cycle
    typedef struct packed {
        logic take;      // any break accepted this cycle
        logic by_nm;     // accepted through the non-maskable path
        logic by_mask;   // accepted through the maskable path
    } brk_grant_t;

    // A new break outranks a return-from-break strobe in the same cycle
    function automatic flag_op_e pick_flag_op(input logic take, input logic rtb);
        if (take)
            return FLAG_SET;
        else if (rtb)
            return FLAG_CLEAR;
        else
            return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/brk_arbiter.sv
module brk_arbiter
    import dbg_brk_pkg::*;
(
    input  logic       rst,
    input  logic       lvl_req,
    input  logic       nm_req,
    input  logic       bip,
    input  logic       eip,
    output brk_grant_t grant
);

    logic mask_ok;

    always_comb begin
        // The maskable path waits until nothing is being serviced
        mask_ok       = lvl_req && !bip && !eip;
        grant.by_nm   = !rst && nm_req;
        grant.by_mask = !rst && mask_ok;
        grant.take    = grant.by_nm || grant.by_mask;
    end

endmodule

// File: rtl/brk_flag.sv
module brk_flag
    import dbg_brk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic rtb,
    output logic bip
);

    flag_op_e op;
    logic     bip_q;

    always_comb op = pick_flag_op(take, rtb);

    always_ff @(posedge clk) begin
        if (rst) begin
            bip_q <= 1'b0;
        end else begin
            unique case (op)
                FLAG_SET:   bip_q <= 1'b1;
                FLAG_CLEAR: bip_q <= 1'b0;
                default:    bip_q <= bip_q;
            endcase
        end
    end

    assign bip = bip_q;

endmodule

// File: rtl/brk_redirect.sv
module brk_redirect
    import dbg_brk_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              take,
    input  logic [ADDR_W-1:0] dec_pc,
    output logic [ADDR_W-1:0] target,
    output logic              ret_we,
    output logic [ADDR_W-1:0] ret_data
);

    localparam logic [ADDR_W-1:0] VEC_OFS    = ADDR_W'(BRK_VEC_OFS);
    localparam logic [ADDR_W-1:0] VEC_TARGET = VEC_BASE + VEC_OFS;

    always_comb begin
        target   = VEC_TARGET;
        ret_we   = take;
        ret_data = dec_pc;
    end

endmodule

// File: rtl/dbg_break_ctrl.sv
module dbg_break_ctrl
    import dbg_brk_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk_lvl_i,
    input  logic              brk_nm_i,
    input  logic              msr_eip_i,
    input  logic              rtb_exec_i,
    input  logic [ADDR_W-1:0] dec_pc_i,
    output logic              take_brk_o,
    output logic [ADDR_W-1:0] brk_target_o,
    output logic              r16_we_o,
    output logic [ADDR_W-1:0] r16_data_o,
    output logic              bip_o,
    output logic              irq_mask_o
);

    brk_grant_t grant;
    logic       bip;

    brk_arbiter u_arb (
        .rst     (rst),
        .lvl_req (brk_lvl_i),
        .nm_req  (brk_nm_i),
        .bip     (bip),
        .eip     (msr_eip_i),
        .grant   (grant)
    );

    brk_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .take (grant.take),
        .rtb  (rtb_exec_i),
        .bip  (bip)
    );

    brk_redirect #(
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) u_redir (
        .take     (grant.take),
        .dec_pc   (dec_pc_i),
        .target   (brk_target_o),
        .ret_we   (r16_we_o),
        .ret_data (r16_data_o)
    );

    assign take_brk_o = grant.take;
    assign bip_o      = bip;
    assign irq_mask_o = bip | grant.take;

endmodule

// File: rtl/dbg_break_ctrl_chk.sv
module dbg_break_ctrl_chk #(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              brk_lvl_i,
    input logic              brk_nm_i,
    input logic              msr_eip_i,
    input logic              rtb_exec_i,
    input logic [ADDR_W-1:0] dec_pc_i,
    input logic              take_brk_o,
    input logic [ADDR_W-1:0] brk_target_o,
    input logic              r16_we_o,
    input logic [ADDR_W-1:0] r16_data_o,
    input logic              bip_o,
    input logic              irq_mask_o
);

    localparam logic [ADDR_W-1:0] EXP_VEC = VEC_BASE + ADDR_W'(32'h18);

    AST_VEC_TARGET: assert property (@(posedge clk) disable iff (rst)
        take_brk_o |-> brk_target_o == EXP_VEC);                                 // R1
    AST_R16_WRITE: assert property (@(posedge clk) disable iff (rst)
        take_brk_o |-> (r16_we_o && r16_data_o == dec_pc_i));                    // R2
    AST_R16_QUIET: assert property (@(posedge clk) disable iff (rst)
        !take_brk_o |-> !r16_we_o);                                              // R2
    AST_BIP_SET: assert property (@(posedge clk) disable iff (rst)
        take_brk_o |=> bip_o);                                                   // R3
    AST_MASK_GATED: assert property (@(posedge clk) disable iff (rst)
        (!brk_nm_i && (bip_o || msr_eip_i)) |-> !take_brk_o);                    // R4
    AST_NM_TAKEN: assert property (@(posedge clk) disable iff (rst)
        brk_nm_i |-> take_brk_o);                                                // R5
    AST_BIP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rtb_exec_i && !take_brk_o) |=> !bip_o);                                 // R6
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_mask_o == (bip_o || take_brk_o));                                    // R7
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (bip_o && brk_lvl_i && !brk_nm_i) |-> !take_brk_o);                      // R8
    AST_NEW_WINS: assert property (@(posedge clk) disable iff (rst)
        (rtb_exec_i && take_brk_o) |=> bip_o);                                   // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (!take_brk_o && !r16_we_o));                                     // R10
    AST_RESET_BIP: assert property (@(posedge clk)
        rst |=> !bip_o);                                                         // R10

endmodule

bind dbg_break_ctrl dbg_break_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .brk_lvl_i    (brk_lvl_i),
    .brk_nm_i     (brk_nm_i),
    .msr_eip_i    (msr_eip_i),
    .rtb_exec_i   (rtb_exec_i),
    .dec_pc_i     (dec_pc_i),
    .take_brk_o   (take_brk_o),
    .brk_target_o (brk_target_o),
    .r16_we_o     (r16_we_o),
    .r16_data_o   (r16_data_o),
    .bip_o        (bip_o),
    .irq_mask_o   (irq_mask_o)
);

// File: tb/dbg_break_ctrl_tb.sv
module dbg_break_ctrl_tb;

    localparam int unsigned       AW   = 32;
    localparam logic [AW-1:0]     BASE = 32'hFFFF_FFF0;
    localparam logic [AW-1:0]     VEC  = 32'h0000_0008;  // BASE + 0x18 wraps

    typedef struct {
        string         req;
        logic          take;
        logic [AW-1:0] target;
        logic          we;
        logic [AW-1:0] data;
        logic          bip;
        logic          mask;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          brk_lvl_i = 1'b0;
    logic          brk_nm_i = 1'b0;
    logic          msr_eip_i = 1'b0;
    logic          rtb_exec_i = 1'b0;
    logic [AW-1:0] dec_pc_i = '0;
    logic          take_brk_o;
    logic [AW-1:0] brk_target_o;
    logic          r16_we_o;
    logic [AW-1:0] r16_data_o;
    logic          bip_o;
    logic          irq_mask_o;

    int   total = 0;
    int   bad = 0;
    logic model_bip = 1'b0;
    logic done = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    dbg_break_ctrl #(.ADDR_W(AW), .VEC_BASE(BASE)) u_dut (
        .clk(clk), .rst(rst), .brk_lvl_i(brk_lvl_i), .brk_nm_i(brk_nm_i),
        .msr_eip_i(msr_eip_i), .rtb_exec_i(rtb_exec_i), .dec_pc_i(dec_pc_i),
        .take_brk_o(take_brk_o), .brk_target_o(brk_target_o),
        .r16_we_o(r16_we_o), .r16_data_o(r16_data_o),
        .bip_o(bip_o), .irq_mask_o(irq_mask_o)
    );

    task automatic cmp(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the outputs the requirements predict
    task automatic step(input string req, input logic r, input logic lvl,
                        input logic nm, input logic eip, input logic rtb,
                        input logic [AW-1:0] pc);
        exp_t e;
        logic tk;
        @(negedge clk);
        rst = r; brk_lvl_i = lvl; brk_nm_i = nm;
        msr_eip_i = eip; rtb_exec_i = rtb; dec_pc_i = pc;
        tk = !r && (nm || (lvl && !model_bip && !eip));   // R4 R5 R10
        e.req    = req;
        e.take   = tk;
        e.target = VEC;                                    // R1
        e.we     = tk;                                     // R2
        e.data   = pc;
        e.bip    = model_bip;
        e.mask   = model_bip || tk;                        // R7
        q.push_back(e);
        if (r)        model_bip = 1'b0;                    // R10
        else if (tk)  model_bip = 1'b1;                    // R3 R9
        else if (rtb) model_bip = 1'b0;                    // R6
    endtask

    // Monitor: compare outputs shortly after inputs settle, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.req, "take", AW'(take_brk_o), AW'(e.take));
                cmp(e.req, "we",   AW'(r16_we_o),   AW'(e.we));
                cmp(e.req, "bip",  AW'(bip_o),      AW'(e.bip));
                cmp(e.req, "mask", AW'(irq_mask_o), AW'(e.mask));
                if (e.take) begin
                    cmp(e.req, "target", brk_target_o, e.target);
                    cmp(e.req, "r16",    r16_data_o,   e.data);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        //   req    rst  lvl  nm   eip  rtb  pc
        step("R10", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1000);
        step("R10", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_1004);
        step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_1008);
        step("R4",  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_100C);
        step("R1",  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2010);
        step("R8",  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2014);
        step("R7",  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2018);
        step("R6",  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_201C);
        step("R6",  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_2020);
        step("R5",  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEE0);
        step("R5",  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEE4);
        step("R5",  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h1234_5678);
        step("R9",  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'hCAFE_0000);
        step("R9",  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hCAFE_0004);
        step("R6",  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hCAFE_0008);
        step("R2",  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hCAFE_000C);
        step("R4",  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_3000);
        step("R10", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_3004);
        step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_3008);
        step("R2",  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_300C);
        @(negedge clk);
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule